// File: doc/BRIEF.md
# Searchable Writeback Scoreboard Queue

This block is an in-order queue of pending writeback records for a small pipelined processor. The execute stage pushes a record for each instruction that will later retire. The writeback stage reads the oldest record and pops it. Any stage can also clear the whole queue in one cycle.

Each record is one of four kinds: an ALU result, a load, a store or a host operation. An ALU record carries 32-bit data and a 5-bit destination register. A load record carries a destination register. A store record carries nothing that takes part in matching. A host record carries a 32-bit payload.

While records wait, the issue stage asks whether a source register is still waiting to be written. Two independent combinational search ports answer this in the same cycle, so both sources of one instruction are checked together. Only ALU and load records whose destination equals the searched index count as a hit. The issue logic stalls on a hit. It searches with the destination itself for load-upper-immediate, and it does not search at all for plain jumps or coprocessor reads.

Top module: `wb_scoreboard_fifo`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, and both search ports report no hit for every index.
- R2: Records leave in the order they entered. `first_kind`, `first_dest` and `first_data` show the oldest record exactly as it was written. Kind encoding: 0 = ALU, 1 = load, 2 = store, 3 = host.
- R3: A search port reports a hit only if some queued record has kind ALU (0) or load (1) and a destination equal to the searched 5-bit index.
- R4: Store (2) and host (3) records never cause a hit, whatever their destination or data. An empty queue never hits.
- R5: The two search ports are independent. In the same cycle they answer different indices, each according to R3.
- R6: `full` is 1 when DEPTH records are queued (default DEPTH 4). A push while full and a pop while empty are ignored and leave the contents unchanged.
- R7: `clr` empties the queue at the next edge. It takes priority over a push or a pop in the same cycle.
- R8: A push and a pop in the same cycle, on a queue that is neither empty nor full, keep the occupancy unchanged and work across pointer wrap. The search result in that cycle reflects the contents before the update.
- R9: A record that has been popped no longer causes a hit. Only records that are still queued are searched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty the queue at the next edge |
| enq_valid | input | 1 | Push request |
| enq_kind | input | 2 | Kind of the record pushed |
| enq_dest | input | 5 | Destination register of the record pushed |
| enq_data | input | 32 | Data or payload of the record pushed |
| deq_ready | input | 1 | Pop request |
| first_kind | output | 2 | Kind of the oldest record |
| first_dest | output | 5 | Destination of the oldest record |
| first_data | output | 32 | Data of the oldest record |
| full | output | 1 | Queue holds DEPTH records |
| empty | output | 1 | Queue holds no record |
| srch_a_idx | input | 5 | Register index searched on port A |
| srch_a_hit | output | 1 | Port A found a pending write |
| srch_b_idx | input | 5 | Register index searched on port B |
| srch_b_hit | output | 1 | Port B found a pending write |

## Verification
The search ports are combinational over the stored state, so any fault in that state shows up in the same cycle. A stale valid bit, a wrong pointer or a corrupted record causes a hit for an index that is no longer pending, or the loss of one that is. It also shows up as a wrong oldest record or a wrong full/empty flag, in the cycle right after the bad update. Because of this, the bench sweeps all 32 indices on both ports before every clock edge. It compares each answer with its own model of the queue, so a divergence is caught in the first cycle it exists.

// File: rtl/wbsb_pkg.sv
`timescale 1ns/1ps
package wbsb_pkg;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    WB_KIND_ALU   = 2'd0,
    WB_KIND_LOAD  = 2'd1,
    WB_KIND_STORE = 2'd2,
    WB_KIND_HOST  = 2'd3
  } wb_kind_e;

  typedef struct packed {
    wb_kind_e            kind;
    logic [REG_W-1:0]    dest;
    logic [DATA_W-1:0]   data;
  } wb_rec_t;

  // A record names a pending register write only for ALU and load kinds.
  function automatic logic rec_writes_reg(wb_rec_t rec, logic [REG_W-1:0] idx);
    return ((rec.kind == WB_KIND_ALU) || (rec.kind == WB_KIND_LOAD)) && (rec.dest == idx);
  endfunction
endpackage

// File: rtl/wbsb_ctrl.sv
`timescale 1ns/1ps
module wbsb_ctrl #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enq_valid,
  input  logic             deq_ready,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [DEPTH-1:0] slot_valid,
  output logic             ev_push,
  output logic             ev_pop,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] count_q;
  logic [DEPTH-1:0] valid_q;

  function automatic logic [PTR_W-1:0] ptr_step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_q == CNT_MAX);
  assign empty_o = (count_q == '0);
  assign ev_push = enq_valid && !full_o && !clr;
  assign ev_pop  = deq_ready && !empty_o && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      valid_q <= '0;
    end else begin
      if (ev_push) begin
        wr_q           <= ptr_step(wr_q);
        valid_q[wr_q]  <= 1'b1;
      end
      if (ev_pop) begin
        rd_q           <= ptr_step(rd_q);
        valid_q[rd_q]  <= 1'b0;
      end
      case ({ev_push, ev_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign wr_ptr     = wr_q;
  assign rd_ptr     = rd_q;
  assign slot_valid = valid_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty_o); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && enq_valid && !deq_ready && !clr) |=> full_o); // R6
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && deq_ready && !enq_valid && !clr) |=> empty_o); // R6
  AST_PUSH_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && ev_pop) |=> ($stable(full_o) && $stable(empty_o))); // R8
  AST_VALID_MATCH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid_q) == int'(count_q))); // R9
endmodule

// File: rtl/wbsb_slots.sv
`timescale 1ns/1ps
module wbsb_slots
  import wbsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     ev_push,
  input  logic [$clog2(DEPTH)-1:0] wr_ptr,
  input  wb_rec_t                  wr_rec,
  output wb_rec_t                  slots [DEPTH]
);
  wb_rec_t mem_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ev_push && (wr_ptr == ($clog2(DEPTH))'(s)))
        mem_q[s] <= wr_rec;
    end
    assign slots[s] = mem_q[s];
  end
endmodule

// File: rtl/wbsb_search.sv
`timescale 1ns/1ps
module wbsb_search
  import wbsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  wb_rec_t          slots [DEPTH],
  input  logic [DEPTH-1:0] slot_valid,
  input  logic [REG_W-1:0] idx,
  output logic             hit
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign slot_hit[s] = slot_valid[s] && rec_writes_reg(slots[s], idx);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/wb_scoreboard_fifo.sv
`timescale 1ns/1ps
module wb_scoreboard_fifo
  import wbsb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enq_valid,
  input  logic [1:0]        enq_kind,
  input  logic [REG_W-1:0]  enq_dest,
  input  logic [DATA_W-1:0] enq_data,
  input  logic              deq_ready,
  output logic [1:0]        first_kind,
  output logic [REG_W-1:0]  first_dest,
  output logic [DATA_W-1:0] first_data,
  output logic              full,
  output logic              empty,
  input  logic [REG_W-1:0]  srch_a_idx,
  output logic              srch_a_hit,
  input  logic [REG_W-1:0]  srch_b_idx,
  output logic              srch_b_hit
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [DEPTH-1:0] slot_valid;
  logic             ev_push, ev_pop;
  wb_rec_t          wr_rec;
  wb_rec_t          slots [DEPTH];
  wb_rec_t          head;

  assign wr_rec = '{kind: wb_kind_e'(enq_kind), dest: enq_dest, data: enq_data};

  wbsb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .enq_valid(enq_valid), .deq_ready(deq_ready),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .slot_valid(slot_valid),
    .ev_push(ev_push), .ev_pop(ev_pop),
    .full_o(full), .empty_o(empty)
  );

  wbsb_slots #(.DEPTH(DEPTH)) u_slots (
    .clk(clk), .ev_push(ev_push), .wr_ptr(wr_ptr),
    .wr_rec(wr_rec), .slots(slots)
  );

  wbsb_search #(.DEPTH(DEPTH)) u_srch_a (
    .slots(slots), .slot_valid(slot_valid), .idx(srch_a_idx), .hit(srch_a_hit)
  );

  wbsb_search #(.DEPTH(DEPTH)) u_srch_b (
    .slots(slots), .slot_valid(slot_valid), .idx(srch_b_idx), .hit(srch_b_hit)
  );

  assign head       = slots[rd_ptr];
  assign first_kind = head.kind;
  assign first_dest = head.dest;
  assign first_data = head.data;

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!srch_a_hit && !srch_b_hit)); // R4
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R6
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |-> slot_valid[rd_ptr]); // R2
endmodule

// File: tb/wb_scoreboard_fifo_tb.sv
`timescale 1ns/1ps
module wb_scoreboard_fifo_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, enq_valid = 1'b0, deq_ready = 1'b0;
  logic [1:0] enq_kind = '0;
  logic [4:0] enq_dest = '0, srch_a_idx = '0, srch_b_idx = '0;
  logic [31:0] enq_data = '0;
  logic [1:0] first_kind;
  logic [4:0] first_dest;
  logic [31:0] first_data;
  logic full, empty, srch_a_hit, srch_b_hit;

  int nchk = 0, nbad = 0;
  logic [1:0]  m_kind [DEPTH];
  logic [4:0]  m_dest [DEPTH];
  logic [31:0] m_data [DEPTH];
  int m_cnt = 0;

  always #2 clk = ~clk;

  wb_scoreboard_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enq_valid(enq_valid),
    .enq_kind(enq_kind), .enq_dest(enq_dest), .enq_data(enq_data),
    .deq_ready(deq_ready), .first_kind(first_kind), .first_dest(first_dest),
    .first_data(first_data), .full(full), .empty(empty),
    .srch_a_idx(srch_a_idx), .srch_a_hit(srch_a_hit),
    .srch_b_idx(srch_b_idx), .srch_b_hit(srch_b_hit)
  );

  function automatic logic model_hit(logic [4:0] idx);
    logic h = 1'b0;
    for (int i = 0; i < m_cnt; i++)
      if (m_kind[i] < 2'd2 && m_dest[i] == idx) h = 1'b1;
    return h;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // Sweep every index on both ports, then check flags and head.
  task automatic observe(input string tag);
    for (int i = 0; i < 32; i++) begin
      srch_a_idx = 5'(i);
      srch_b_idx = 5'(31 - i);
      #0.05;
      chk(tag, $sformatf("hitA idx=%0d", i), {31'd0, srch_a_hit}, {31'd0, model_hit(5'(i))});
      chk(tag, $sformatf("hitB idx=%0d", 31 - i), {31'd0, srch_b_hit}, {31'd0, model_hit(5'(31 - i))});
    end
    chk(tag, "empty", {31'd0, empty}, {31'd0, m_cnt == 0});
    chk(tag, "full", {31'd0, full}, {31'd0, m_cnt == DEPTH});
    if (m_cnt > 0) begin
      chk(tag, "first_kind", {30'd0, first_kind}, {30'd0, m_kind[0]});
      chk(tag, "first_dest", {27'd0, first_dest}, {27'd0, m_dest[0]});
      chk(tag, "first_data", first_data, m_data[0]);
    end
  endtask

  task automatic step(input logic c, input logic ev, input logic [1:0] k,
                      input logic [4:0] d, input logic [31:0] dat,
                      input logic dr, input string tag);
    logic do_pop, do_push;
    @(negedge clk);
    clr = c; enq_valid = ev; enq_kind = k; enq_dest = d; enq_data = dat; deq_ready = dr;
    observe(tag);
    @(posedge clk);
    if (c) m_cnt = 0;
    else begin
      do_pop  = dr && (m_cnt > 0);
      do_push = ev && (m_cnt < DEPTH);
      if (do_pop) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          m_kind[i] = m_kind[i+1]; m_dest[i] = m_dest[i+1]; m_data[i] = m_data[i+1];
        end
        m_cnt--;
      end
      if (do_push) begin
        m_kind[m_cnt] = k; m_dest[m_cnt] = d; m_data[m_cnt] = dat;
        m_cnt++;
      end
    end
  endtask

  initial begin
    #(4.0 * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    observe("R1");
    rst_n = 1'b1;
    // R3 R5: mixed kinds, two ports queried together
    step(0, 1, 2'd0, 5'd3, 32'h1111_0003, 0, "R3");
    step(0, 1, 2'd1, 5'd7, 32'h0, 0, "R3");
    step(0, 1, 2'd2, 5'd9, 32'hdead_0009, 0, "R4");
    step(0, 1, 2'd3, 5'd12, 32'hbeef_000c, 0, "R4");
    step(0, 0, 2'd0, 5'd0, 32'h0, 0, "R5");
    // R6: push while full is ignored
    step(0, 1, 2'd0, 5'd20, 32'h2020_2020, 0, "R6");
    step(0, 0, 2'd0, 5'd0, 32'h0, 0, "R6");
    // R2 R9: drain in order, popped entries stop hitting
    for (int i = 0; i < DEPTH; i++) step(0, 0, 2'd0, 5'd0, 32'h0, 1, "R9");
    // R6: pop while empty is ignored
    step(0, 0, 2'd0, 5'd0, 32'h0, 1, "R6");
    step(0, 0, 2'd0, 5'd0, 32'h0, 0, "R6");
    // R8: concurrent push/pop around the wrap point
    step(0, 1, 2'd1, 5'd4, 32'h4, 0, "R8");
    step(0, 1, 2'd0, 5'd5, 32'h5, 0, "R8");
    for (int i = 0; i < 10; i++) step(0, 1, 2'(i % 4), 5'(i + 6), 32'(i * 7), 1, "R8");
    step(0, 0, 2'd0, 5'd0, 32'h0, 0, "R2");
    // R7: clear beats push and pop
    step(1, 1, 2'd0, 5'd1, 32'h1, 1, "R7");
    step(0, 0, 2'd0, 5'd0, 32'h0, 0, "R7");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 2'd0, 5'(i), 32'(i), 0, "R2");
    step(1, 0, 2'd0, 5'd0, 32'h0, 0, "R7");
    step(0, 0, 2'd0, 5'd0, 32'h0, 0, "R7");
    // Random mix against the model
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] r = 8'($urandom);
      step(r[7:4] == 4'h0, r[0] | r[1], 2'($urandom), 5'($urandom % 8), $urandom,
           r[2] & ~r[3], "R3");
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule